// File: doc/BRIEF.md
# Pulse-Swallow Synthesiser Divider Chain

This block holds the two digital dividers that feed the phase detector of an integer-N frequency synthesiser. On the oscillator side, a dual-modulus prescaler that divides by N or N+1 is steered by a main counter and a swallow counter. One feedback pulse therefore marks every M·N + A oscillator cycles. On the reference side, a plain programmable counter divides the reference clock by R. The receive and transmit loops use the same block, and the instances differ only in the values loaded into them.

The prescaler modulus comes from a 3-bit code. The main count M, the swallow count A and the code are sampled only when a feedback period closes, so a reprogramming in mid-period never produces a short or long cycle. If A and N do not fit together, or M and A do not fit together, the block raises an error flag and falls back to a fixed, predictable ratio. The reference divider follows the same rule: a new R value takes effect when the current reference period ends.

Top module: `synth_divchain`

## Requirements
- R1: With A < N, A ≤ M and M ≥ 1, the spacing between consecutive `fb_pulse` assertions is exactly M·N + A cycles of `vco_clk`.
- R2: When `ps_code[2]` is 0, the prescaler modulus pair is 8/9, whatever `ps_code[1:0]` hold.
- R3: `ps_code` values 3'b100, 3'b101, 3'b110 and 3'b111 give modulus pairs 16/17, 32/33, 64/65 and 128/129.
- R4: Within each feedback period, `mod_hi` is high for the first A prescaler cycles and low for the remaining M−A. It changes only at a prescaler cycle boundary, so it is high for A·(N+1) `vco_clk` cycles per period.
- R5: If the latched values have A ≥ N, M < A or M = 0, `cfg_err` is 1 for that period, `mod_hi` stays 0, and the period lasts max(M,1)·N cycles. Otherwise `cfg_err` is 0.
- R6: `m_val`, `a_val` and `ps_code` are sampled only on the clock edge that ends a `fb_pulse` cycle. A change in mid-period leaves the current period at its old length, and the change applies from the next period.
- R7: `fb_pulse` is high for exactly one `vco_clk` cycle per period.
- R8: The spacing between `ref_pulse` assertions is R cycles of `ref_clk` for `r_val` = R ≥ 1; `r_val` = 0 acts as 1. For R ≥ 2 each pulse is one cycle wide.
- R9: `r_val` is sampled only on the `ref_clk` edge that ends a `ref_pulse` cycle, so a period in progress completes at its old length.
- R10: While `rst_n` is low, `fb_pulse`, `ref_pulse`, `mod_hi` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator clock being divided |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both dividers |
| m_val | input | 11 | Main counter value M |
| a_val | input | 7 | Swallow counter value A |
| ps_code | input | 3 | Prescaler modulus code |
| r_val | input | 15 | Reference division ratio R |
| fb_pulse | output | 1 | One-cycle pulse at the end of each feedback period |
| ref_pulse | output | 1 | One-cycle pulse at the end of each reference period |
| mod_hi | output | 1 | Modulus control: 1 selects N+1, 0 selects N |
| cfg_err | output | 1 | Latched values for the current period are inconsistent |

## Verification
The hardest situation to reach is a reprogramming that lands inside a period and must not shorten it. The stimulus waits for a feedback pulse, loads one setting, moves a few cycles into the new period and then loads a second setting. It then measures two whole periods in a row, and the same is done on the reference side. Random settings are drawn so that M is sometimes equal to A and A sometimes exceeds N. A directed case also runs the largest swallow count against the 128/129 prescaler, which is the longest period in the test.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

   // log2 of the lower prescaler modulus selected by a 3-bit code.
   // Top bit clear: smallest modulus (2**base). Top bit set: 2**(base+1+low bits).
   function automatic int unsigned sdc_modulus_log2(input logic [2:0] code,
                                                     input int unsigned base_log2);
      int unsigned lg;
      if (code[2]) lg = base_log2 + 1 + 32'(code[1:0]);
      else         lg = base_log2;
      return lg;
   endfunction

endpackage

// File: rtl/sdc_prescaler.sv
module sdc_prescaler #(
   parameter int unsigned NW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NW-1:0] nxt_n,
   input  logic          nxt_hi,
   output logic          tick
);
   if (NW < 2) begin : g_bad_width
      $error("sdc_prescaler: NW must be at least 2");
   end

   logic [NW-1:0] pc_q;

   assign tick = (pc_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pc_q <= '0;
      else if (tick)  pc_q <= nxt_hi ? nxt_n : nxt_n - 1'b1;
      else            pc_q <= pc_q - 1'b1;
   end

   AST_PS_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R7
endmodule

// File: rtl/sdc_swallow_ctl.sv
module sdc_swallow_ctl
   import sdc_pkg::*;
#(
   parameter int unsigned M_W       = 11,
   parameter int unsigned A_W       = 7,
   parameter int unsigned NW        = 8,
   parameter int unsigned BASE_LOG2 = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [M_W-1:0] m_in,
   input  logic [A_W-1:0] a_in,
   input  logic [2:0]     code_in,
   input  logic           tick,
   output logic [NW-1:0]  nxt_n,
   output logic           nxt_hi,
   output logic           mod_hi,
   output logic           fb_pulse,
   output logic           cfg_err
);
   localparam int unsigned MX1 = (M_W > A_W) ? M_W : A_W;
   localparam int unsigned CW  = ((MX1 > NW) ? MX1 : NW) + 1;

   if (M_W < 2 || A_W < 1) begin : g_bad_width
      $error("sdc_swallow_ctl: counter widths too small");
   end
   if (NW < BASE_LOG2 + 5) begin : g_bad_nw
      $error("sdc_swallow_ctl: NW cannot hold the largest modulus");
   end

   logic           primed_q;
   logic [NW-1:0]  n_q;
   logic [M_W-1:0] m_rem;
   logic [A_W-1:0] a_rem;
   logic           err_q;

   logic [NW-1:0]  n_in;
   logic           err_in;
   logic [M_W-1:0] m_eff;
   logic [A_W-1:0] a_eff;
   logic [A_W-1:0] a_dec;
   logic           last_cyc;
   logic           reload;

   always_comb begin
      n_in   = NW'(1) << sdc_modulus_log2(code_in, BASE_LOG2);
      err_in = (m_in == '0) || (CW'(a_in) >= CW'(n_in)) || (CW'(m_in) < CW'(a_in));
      m_eff  = (m_in == '0) ? M_W'(1) : m_in;
      a_eff  = err_in ? '0 : a_in;
      a_dec  = (a_rem != '0) ? a_rem - 1'b1 : '0;
   end

   assign last_cyc = tick && (m_rem == M_W'(1));
   assign reload   = !primed_q || last_cyc;
   assign fb_pulse = primed_q && last_cyc;
   assign mod_hi   = (a_rem != '0);
   assign cfg_err  = err_q;

   always_comb begin
      if (reload) begin
         nxt_n  = n_in;
         nxt_hi = (a_eff != '0);
      end else begin
         nxt_n  = n_q;
         nxt_hi = (a_dec != '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed_q <= 1'b0;
         n_q      <= '0;
         m_rem    <= '0;
         a_rem    <= '0;
         err_q    <= 1'b0;
      end else if (reload) begin
         primed_q <= 1'b1;
         n_q      <= n_in;
         m_rem    <= m_eff;
         a_rem    <= a_eff;
         err_q    <= err_in;
      end else if (tick) begin
         m_rem    <= m_rem - 1'b1;
         a_rem    <= a_dec;
      end
   end

   AST_MC_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mod_hi) |-> $past(tick)); // R4
   AST_MC_HELD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && !tick) |=> $stable(mod_hi)); // R4
   AST_ERR_NO_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !mod_hi); // R5
   AST_FB_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      fb_pulse |=> !fb_pulse); // R7
   AST_CFG_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && !fb_pulse) |=> ($stable(n_q) && $stable(cfg_err))); // R6
endmodule

// File: rtl/sdc_ref_div.sv
module sdc_ref_div #(
   parameter int unsigned R_W = 15
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [R_W-1:0] r_in,
   output logic           pulse
);
   if (R_W < 2) begin : g_bad_width
      $error("sdc_ref_div: R_W must be at least 2");
   end

   logic           primed_q;
   logic [R_W-1:0] cnt_q;
   logic [R_W-1:0] len_q;
   logic [R_W-1:0] r_eff;
   logic           term;

   assign r_eff = (r_in == '0) ? R_W'(1) : r_in;
   assign term  = (cnt_q == '0);
   assign pulse = primed_q && term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed_q <= 1'b0;
         cnt_q    <= '0;
         len_q    <= '0;
      end else if (!primed_q || term) begin
         primed_q <= 1'b1;
         cnt_q    <= r_eff - 1'b1;
         len_q    <= r_eff;
      end else begin
         cnt_q    <= cnt_q - 1'b1;
      end
   end

   AST_REF_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && (r_in > R_W'(1))) |=> !pulse); // R8
   AST_REF_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && !pulse) |=> $stable(len_q)); // R9
endmodule

// File: rtl/synth_divchain.sv
module synth_divchain #(
   parameter int unsigned M_W       = 11,
   parameter int unsigned A_W       = 7,
   parameter int unsigned R_W       = 15,
   parameter int unsigned BASE_LOG2 = 3
) (
   input  logic           vco_clk,
   input  logic           ref_clk,
   input  logic           rst_n,
   input  logic [M_W-1:0] m_val,
   input  logic [A_W-1:0] a_val,
   input  logic [2:0]     ps_code,
   input  logic [R_W-1:0] r_val,
   output logic           fb_pulse,
   output logic           ref_pulse,
   output logic           mod_hi,
   output logic           cfg_err
);
   localparam int unsigned NW = BASE_LOG2 + 5;

   logic [NW-1:0] nxt_n;
   logic          nxt_hi;
   logic          ps_tick;

   sdc_prescaler #(.NW(NW)) u_prescaler (
      .clk    (vco_clk),
      .rst_n  (rst_n),
      .nxt_n  (nxt_n),
      .nxt_hi (nxt_hi),
      .tick   (ps_tick)
   );

   sdc_swallow_ctl #(
      .M_W       (M_W),
      .A_W       (A_W),
      .NW        (NW),
      .BASE_LOG2 (BASE_LOG2)
   ) u_swallow (
      .clk      (vco_clk),
      .rst_n    (rst_n),
      .m_in     (m_val),
      .a_in     (a_val),
      .code_in  (ps_code),
      .tick     (ps_tick),
      .nxt_n    (nxt_n),
      .nxt_hi   (nxt_hi),
      .mod_hi   (mod_hi),
      .fb_pulse (fb_pulse),
      .cfg_err  (cfg_err)
   );

   sdc_ref_div #(.R_W(R_W)) u_ref_div (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .r_in  (r_val),
      .pulse (ref_pulse)
   );
endmodule

// File: tb/synth_divchain_bench.sv
`timescale 1ns/1ps
module synth_divchain_bench;
   localparam int MW = 11;
   localparam int AW = 7;
   localparam int RW = 15;
   localparam int unsigned WD_LIMIT = 190000;

   logic          vco_clk = 1'b0;
   logic          ref_clk = 1'b0;
   logic          rst_n   = 1'b0;
   logic [MW-1:0] m_val   = MW'(2);
   logic [AW-1:0] a_val   = '0;
   logic [2:0]    ps_code = 3'b000;
   logic [RW-1:0] r_val   = RW'(4);
   logic          fb_pulse, ref_pulse, mod_hi, cfg_err;

   always #2 vco_clk = ~vco_clk;
   always #3 ref_clk = ~ref_clk;

   synth_divchain u_synth_divchain (
      .vco_clk, .ref_clk, .rst_n, .m_val, .a_val, .ps_code, .r_val,
      .fb_pulse, .ref_pulse, .mod_hi, .cfg_err
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint exp_n(input logic [2:0] code);
      return code[2] ? (longint'(16) << code[1:0]) : 64'd8;
   endfunction
   function automatic bit exp_err(input longint m, input longint a, input logic [2:0] code);
      return (m == 0) || (a >= exp_n(code)) || (m < a);
   endfunction
   function automatic longint exp_ratio(input longint m, input longint a, input logic [2:0] code);
      if (exp_err(m, a, code)) return ((m == 0) ? 1 : m) * exp_n(code);
      return m * exp_n(code) + a;
   endfunction
   function automatic longint exp_mc(input longint m, input longint a, input logic [2:0] code);
      if (exp_err(m, a, code)) return 0;
      return a * (exp_n(code) + 1);
   endfunction

   // feedback monitor, sampled on the falling edge
   event fb_ev, ref_ev;
   longint fb_cnt = 0, fb_int = 0, fb_mc_acc = 0, fb_mc = 0, fb_dbl = 0;
   bit fb_prev = 1'b0;
   always @(negedge vco_clk) begin
      if (!rst_n) begin
         fb_cnt = 0; fb_mc_acc = 0; fb_prev = 1'b0;
      end else begin
         fb_cnt++;
         if (mod_hi) fb_mc_acc++;
         if (fb_pulse) begin
            if (fb_prev) fb_dbl++;
            fb_int = fb_cnt; fb_mc = fb_mc_acc;
            fb_cnt = 0; fb_mc_acc = 0;
            fb_prev = 1'b1;
            -> fb_ev;
         end else begin
            fb_prev = 1'b0;
         end
      end
   end

   longint ref_cnt = 0, ref_int = 0, ref_dbl = 0;
   bit ref_prev = 1'b0;
   always @(negedge ref_clk) begin
      if (!rst_n) begin
         ref_cnt = 0; ref_prev = 1'b0;
      end else begin
         ref_cnt++;
         if (ref_pulse) begin
            if (ref_prev) ref_dbl++;
            ref_int = ref_cnt; ref_cnt = 0;
            ref_prev = 1'b1;
            -> ref_ev;
         end else begin
            ref_prev = 1'b0;
         end
      end
   end

   int unsigned wd_cnt = 0;
   always @(posedge vco_clk) begin
      wd_cnt = wd_cnt + 1;
      if (wd_cnt == WD_LIMIT) begin
         checks++; errors++;
         $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", wd_cnt, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // called at a feedback pulse: load a setting, measure the period it governs
   task automatic fb_step(input longint m, input longint a, input logic [2:0] code,
                          input string req);
      longint d0;
      m_val = MW'(m); a_val = AW'(a); ps_code = code;
      d0 = fb_dbl;
      @(fb_ev);
      check(fb_int == exp_ratio(m, a, code), req, "feedback period", fb_int, exp_ratio(m, a, code));
      check(fb_mc == exp_mc(m, a, code), "R4", "mod_hi cycles", fb_mc, exp_mc(m, a, code));
      check(cfg_err == exp_err(m, a, code), "R5", "cfg_err", longint'(cfg_err), longint'(exp_err(m, a, code)));
      check(fb_dbl == d0, "R7", "fb_pulse width", fb_dbl - d0, 0);
   endtask

   task automatic ref_step(input longint r, input string req);
      longint d0, e;
      r_val = RW'(r);
      d0 = ref_dbl;
      e = (r == 0) ? 1 : r;
      @(ref_ev);
      check(ref_int == e, req, "reference period", ref_int, e);
      if (e >= 2) check(ref_dbl == d0, "R8", "ref_pulse width", ref_dbl - d0, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge vco_clk);
      // R10: outputs quiet during reset
      check(fb_pulse == 1'b0, "R10", "fb_pulse in reset", longint'(fb_pulse), 0);
      check(ref_pulse == 1'b0, "R10", "ref_pulse in reset", longint'(ref_pulse), 0);
      check(mod_hi == 1'b0, "R10", "mod_hi in reset", longint'(mod_hi), 0);
      check(cfg_err == 1'b0, "R10", "cfg_err in reset", longint'(cfg_err), 0);
      rst_n = 1'b1;

      @(fb_ev);
      fb_step(2, 0, 3'b000, "R1");
      fb_step(3, 2, 3'b000, "R2");       // 26
      fb_step(3, 2, 3'b011, "R2");       // low code bits ignored
      fb_step(3, 2, 3'b001, "R2");
      fb_step(2, 1, 3'b100, "R3");       // 33
      fb_step(2, 1, 3'b101, "R3");       // 65
      fb_step(2, 1, 3'b110, "R3");       // 129
      fb_step(2, 1, 3'b111, "R3");       // 257
      fb_step(5, 5, 3'b000, "R1");       // M equal to A
      fb_step(2, 7, 3'b000, "R5");       // A > M
      fb_step(10, 8, 3'b000, "R5");      // A equal to N
      fb_step(2, 5, 3'b100, "R5");       // M < A
      fb_step(0, 0, 3'b101, "R5");       // M zero
      fb_step(127, 127, 3'b111, "R1");   // largest swallow count
      fb_step(1, 0, 3'b000, "R1");       // shortest period

      // R6: mid-period change keeps the current period
      m_val = MW'(3); a_val = AW'(1); ps_code = 3'b100;
      repeat (10) @(negedge vco_clk);
      m_val = MW'(2); a_val = '0; ps_code = 3'b000;
      @(fb_ev);
      check(fb_int == 49, "R6", "period after mid change", fb_int, 49);
      @(fb_ev);
      check(fb_int == 16, "R6", "period with new setting", fb_int, 16);

      for (int i = 0; i < 24; i++) begin
         logic [2:0] c;
         longint n, m, a, lim;
         c = 3'($urandom % 8);
         n = exp_n(c);
         m = 1 + longint'($urandom % 20);
         lim = (n - 1 < m) ? n - 1 : m;
         if ($urandom % 5 == 0) a = longint'($urandom % 128);
         else                   a = longint'($urandom % (lim + 1));
         fb_step(m, a, c, "R1");
      end

      // reference divider
      @(ref_ev);
      ref_step(5, "R8");
      ref_step(2, "R8");
      ref_step(1, "R8");
      ref_step(0, "R8");
      ref_step(100, "R8");
      ref_step(3000, "R8");
      r_val = RW'(40);
      repeat (10) @(negedge ref_clk);
      r_val = RW'(9);
      @(ref_ev);
      check(ref_int == 40, "R9", "ref period after mid change", ref_int, 40);
      @(ref_ev);
      check(ref_int == 9, "R9", "ref period with new value", ref_int, 9);
      for (int i = 0; i < 6; i++) begin
         ref_step(2 + longint'($urandom % 200), "R8");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule